// File: doc/BRIEF.md
# SPI Slave Front End with Pause and Address Match

This block is the serial front end of a register device that is controlled over SPI. The chip select, serial clock, serial data input and an active-low pause pin are brought into a faster system clock domain. Edges are detected from the synchronized samples. Bits are shifted in most significant bit first on rising SCK. The first byte of every frame is an identification byte. It must carry a fixed device-type nibble, a zero bit and the two-bit address set by strap pins. Only a frame whose identification byte matches goes any further.

For a matched frame, each later byte is handed to a command decoder as a parallel byte with a one-cycle strobe. The read/write flag from the identification byte and a frame-valid level are also given to the decoder. In a read frame, the decoder supplies bytes that the block shifts out on a tri-statable serial output, changing on falling SCK. The pause pin freezes the transfer in place: the bit and byte positions are kept, SCK edges are ignored and the output is released. When chip select rises, a one-cycle frame-end pulse reports how many complete bytes the frame held.

Top module: `spi_hold_frontend`

## Requirements
- R1: While reset is low and in the cycle after it, `so_en`, `rx_strobe`, `frame_valid` and `frame_end` are all 0.
- R2: SI is sampled on rising SCK, most significant bit first. After a matching identification byte, each completed later byte appears on `rx_byte`, with `rx_strobe` high for exactly one system clock.
- R3: The identification byte is matched when bits 7:4 are 0101, bit 3 is 0 and bits 2:1 equal `strap_addr[1:0]`. Bit 0 is the read/write flag (1 = read). On a match, `frame_valid` rises and stays high until chip select rises, and `rw_bit` holds bit 0.
- R4: When the identification byte does not match, the rest of the frame is ignored. No `rx_strobe` is issued, `frame_valid` stays 0 and `so_en` is never asserted in that frame.
- R5: While chip select is high, `so_en` is 0. A partial byte left when chip select rises is discarded, and the next frame starts at bit 7 of a new identification byte.
- R6: After reset, nothing is accepted until chip select has made a high-to-low transition. A frame already under way at reset release produces no strobe, no `frame_valid` and no `frame_end`.
- R7: A pause pin that goes low while SCK is low pauses the transfer. While paused, SCK edges are not counted and `so_en` is 0. Releasing the pause while SCK is low resumes at the same bit of the same byte.
- R8: In a matched read frame, the byte on `tx_byte` is loaded at the falling SCK edge that begins each byte after the identification byte. It is shifted out on `so_data` MSB first, changing only on falling SCK. In a write frame, `so_en` is never asserted.
- R9: On the chip select rising edge of an accepted frame, `frame_end` pulses for one system clock. `frame_bytes` then holds the number of complete bytes, including the identification byte. A mismatched frame reports 1, and the count saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_pin | input | 1 | Chip select, active low, asynchronous |
| sck_pin | input | 1 | Serial clock, asynchronous |
| si_pin | input | 1 | Serial data in |
| hold_n_pin | input | 1 | Pause request, active low |
| strap_addr | input | 2 | Device address straps |
| tx_byte | input | 8 | Read-back byte from the command decoder |
| so_data | output | 1 | Serial output data |
| so_en | output | 1 | Serial output drive enable (0 = high impedance) |
| rx_byte | output | 8 | Last received command/data byte |
| rx_strobe | output | 1 | One-cycle pulse when `rx_byte` is new |
| rw_bit | output | 1 | Read/write flag of the current frame (1 = read) |
| frame_valid | output | 1 | Identification byte matched in this frame |
| frame_end | output | 1 | One-cycle pulse at the end of an accepted frame |
| frame_bytes | output | 8 | Complete bytes in the frame just ended |

## Verification
The pause request and the reload of the serial output for the next byte can fall into the same synchronized cycle. This happens when the pause pin drops at the very instant SCK falls after the eighth bit of a byte. The bench provokes it by lowering the pause pin in the same time step as that falling SCK, in read frames. While paused it sends ignored SCK pulses, then resumes. It judges the outcome by requiring that the output stays released during the pause. After the resume, the full next read-back byte must arrive MSB first, and the byte count and the received bytes must be unchanged by the pause.

// File: rtl/spi_hold_pkg.sv
// Shared constants, types and the identification-byte check for the
// SPI front end. Assumes an 8-bit byte and a 2-bit strap address.
package spi_hold_pkg;

    localparam int BYTE_W   = 8;
    localparam int STRAP_W  = 2;
    localparam logic [3:0] DEV_TYPE = 4'b0101;

    // Field layout of the identification byte, MSB first on the wire
    typedef struct packed {
        logic [3:0]         dtype;
        logic               zero;
        logic [STRAP_W-1:0] addr;
        logic               rd;
    } id_byte_t;

    // True when the byte names this device type and this strap address
    function automatic logic id_match(input logic [BYTE_W-1:0] b,
                                      input logic [STRAP_W-1:0] strap);
        id_byte_t f;
        f = id_byte_t'(b);
        return (f.dtype == DEV_TYPE) && !f.zero && (f.addr == strap);
    endfunction

endpackage

// File: rtl/spi_hold_sync.sv
// Multi-stage synchronizer with edge detection for a vector of slow,
// asynchronous pins. Assumes each pin holds a level for several clocks.
// All stages reset to 0, so a pin held low through reset shows no edge.
module spi_hold_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] pipe;
    logic [WIDTH-1:0]             prev;

    // Shift the pins through the synchronizer chain and keep the last level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
            prev <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
            prev <= pipe[LAST];
        end
    end

    assign level = pipe[LAST];
    assign rise  = pipe[LAST] & ~prev;
    assign fall  = ~pipe[LAST] & prev;

endmodule

// File: rtl/spi_hold_pause.sv
// Pause tracker: follows the pause pin only while SCK is low, so a pause
// request that arrives during a high SCK phase waits for the next low phase.
// Starts paused out of reset until the synchronized pin shows released.
module spi_hold_pause (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_lvl,
    input  logic hold_n_lvl,
    output logic paused
);
    // Update the pause state from the pin level during SCK low
    always_ff @(posedge clk) begin
        if (!rst_n)        paused <= 1'b1;
        else if (!sck_lvl) paused <= !hold_n_lvl;
    end

    // R7: pause state never changes during a high SCK phase
    a_r7_hold_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sck_lvl) |-> $stable(paused));

endmodule

// File: rtl/spi_hold_rx.sv
// Receive path: bit and byte counters, input shift register, identification
// byte check and byte strobe. Assumes at most one SCK edge per clock and
// that frame start and stop never coincide (both come from one pin level).
module spi_hold_rx
    import spi_hold_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               frame_stop,
    input  logic               sck_rise,
    input  logic               si_lvl,
    input  logic               paused,
    input  logic [STRAP_W-1:0] strap,
    output logic               active,
    output logic               dead,
    output logic               frame_valid,
    output logic               rw_bit,
    output logic               bit_zero,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               rx_strobe,
    output logic [CNT_W-1:0]   byte_cnt
);
    localparam int               BIT_W   = $clog2(BYTE_W);
    localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] next_byte;
    logic              take_bit;

    assign next_byte = {shreg[BYTE_W-2:0], si_lvl};
    assign take_bit  = active && !dead && !paused && sck_rise;
    assign bit_zero  = (bit_cnt == '0);

    // Frame control, bit shifting, byte completion and identification check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active      <= 1'b0;
            dead        <= 1'b0;
            frame_valid <= 1'b0;
            rw_bit      <= 1'b0;
            bit_cnt     <= '0;
            byte_cnt    <= '0;
            shreg       <= '0;
            rx_byte     <= '0;
            rx_strobe   <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            if (frame_start) begin
                active      <= 1'b1;
                dead        <= 1'b0;
                frame_valid <= 1'b0;
                rw_bit      <= 1'b0;
                bit_cnt     <= '0;
                byte_cnt    <= '0;
            end else if (frame_stop) begin
                active      <= 1'b0;
                dead        <= 1'b0;
                frame_valid <= 1'b0;
                bit_cnt     <= '0;
            end else if (take_bit) begin
                shreg   <= next_byte;
                bit_cnt <= bit_cnt + BIT_W'(1);
                if (bit_cnt == BIT_TOP) begin
                    if (byte_cnt == '0) begin
                        if (id_match(next_byte, strap)) begin
                            frame_valid <= 1'b1;
                            rw_bit      <= next_byte[0];
                        end else begin
                            dead <= 1'b1;
                        end
                    end else begin
                        rx_byte   <= next_byte;
                        rx_strobe <= 1'b1;
                    end
                    if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + CNT_W'(1);
                end
            end
        end
    end

    // R2: a byte strobe lasts one clock
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    // R3: a match is only declared when the first byte has just completed
    a_r3_valid_after_id: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_valid) |-> (byte_cnt == CNT_W'(1)));

    // R6: no strobe outside an armed frame
    a_r6_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !rx_strobe);

    // R7: while paused, SCK edges do not move the bit position
    a_r7_paused_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !frame_start && !frame_stop) |=> $stable(bit_cnt));

endmodule

// File: rtl/spi_hold_tx.sv
// Transmit path: loads the decoder's read-back byte at the falling SCK edge
// that opens each byte and shifts it out MSB first on later falling edges.
// Assumes the decoder settles tx_byte within half an SCK period of a strobe.
module spi_hold_tx
    import spi_hold_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              sck_fall,
    input  logic              paused,
    input  logic              feed_ok,
    input  logic              bit_zero,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              so_data,
    output logic              so_en
);
    logic [BYTE_W-1:0] shreg;
    logic              live;

    // Load or shift the output register on accepted falling SCK edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            live  <= 1'b0;
        end else if (frame_start) begin
            live <= 1'b0;
        end else if (sck_fall && !paused && feed_ok) begin
            if (bit_zero) begin
                shreg <= tx_byte;
                live  <= 1'b1;
            end else begin
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign so_data = shreg[BYTE_W-1];
    assign so_en   = live && feed_ok && !paused;

    // R8: output data only moves after a falling SCK edge
    a_r8_so_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(so_data));

endmodule

// File: rtl/spi_hold_frontend.sv
// Top of the SPI slave front end. Synchronizes the pins, tracks pause,
// runs the receive and transmit paths and reports frame end with a byte
// count. Assumes clk runs at least 8x the SCK rate and strap pins are static.
module spi_hold_frontend
    import spi_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n_pin,
    input  logic               sck_pin,
    input  logic               si_pin,
    input  logic               hold_n_pin,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic [BYTE_W-1:0]  tx_byte,
    output logic               so_data,
    output logic               so_en,
    output logic [BYTE_W-1:0]  rx_byte,
    output logic               rx_strobe,
    output logic               rw_bit,
    output logic               frame_valid,
    output logic               frame_end,
    output logic [CNT_W-1:0]   frame_bytes
);
    localparam int PIN_CS   = 0;
    localparam int PIN_SCK  = 1;
    localparam int PIN_SI   = 2;
    localparam int PIN_HOLD = 3;
    localparam int PINS     = 4;

    logic [PINS-1:0]  pin_lvl, pin_rise, pin_fall;
    logic             paused, active, dead, bit_zero, feed_ok;
    logic [CNT_W-1:0] byte_cnt;

    spi_hold_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({hold_n_pin, si_pin, sck_pin, cs_n_pin}),
        .level (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    spi_hold_pause u_pause (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_lvl    (pin_lvl[PIN_SCK]),
        .hold_n_lvl (pin_lvl[PIN_HOLD]),
        .paused     (paused)
    );

    spi_hold_rx #(.CNT_W(CNT_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (pin_fall[PIN_CS]),
        .frame_stop  (pin_rise[PIN_CS]),
        .sck_rise    (pin_rise[PIN_SCK]),
        .si_lvl      (pin_lvl[PIN_SI]),
        .paused      (paused),
        .strap       (strap_addr),
        .active      (active),
        .dead        (dead),
        .frame_valid (frame_valid),
        .rw_bit      (rw_bit),
        .bit_zero    (bit_zero),
        .rx_byte     (rx_byte),
        .rx_strobe   (rx_strobe),
        .byte_cnt    (byte_cnt)
    );

    assign feed_ok = active && frame_valid && rw_bit && !dead;

    spi_hold_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (pin_fall[PIN_CS]),
        .sck_fall    (pin_fall[PIN_SCK]),
        .paused      (paused),
        .feed_ok     (feed_ok),
        .bit_zero    (bit_zero),
        .tx_byte     (tx_byte),
        .so_data     (so_data),
        .so_en       (so_en)
    );

    // Report the end of an accepted frame with its complete byte count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_end   <= 1'b0;
            frame_bytes <= '0;
        end else begin
            frame_end <= pin_rise[PIN_CS] && active;
            if (pin_rise[PIN_CS] && active) frame_bytes <= byte_cnt;
        end
    end

    // R1: quiet outputs in and right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!so_en && !rx_strobe && !frame_valid && !frame_end));

    // R4: a rejected frame never drives the output
    a_r4_dead_silent: assert property (@(posedge clk) disable iff (!rst_n)
        dead |-> !so_en);

    // R5: output released once chip select has been high for a cycle
    a_r5_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_lvl[PIN_CS] && $past(pin_lvl[PIN_CS])) |-> !so_en);

    // R8: output only driven in matched read frames
    a_r8_so_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        so_en |-> (frame_valid && rw_bit));

    // R9: frame end is a single-clock pulse
    a_r9_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);

endmodule

// File: tb/tb_spi_hold_frontend.sv
module tb_spi_hold_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int WATCHDOG   = 190000;
    localparam logic [1:0] STRAP = 2'b10;
    localparam logic [7:0] TX_SEED = 8'h4c;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       hold_n = 1'b1;
    logic [7:0] tx_byte;
    logic       so_data, so_en, rx_strobe, rw_bit, frame_valid, frame_end;
    logic [7:0] rx_byte, frame_bytes;

    int n_checks = 0;
    int n_fail   = 0;
    int strobe_frame = 0;
    int strobe_total = 0;
    int n_end = 0;
    logic [7:0] last_fb = 0;
    logic prev_strobe = 0, prev_end = 0;
    logic [7:0] cap [0:15];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] tx_pat(input int n);
        return 8'(int'(TX_SEED) + n * 59);
    endfunction

    function automatic logic [7:0] dat_pat(input int seed, input int k);
        return 8'((seed * 13) ^ (k * 93) ^ 8'h36);
    endfunction

    assign tx_byte = tx_pat(strobe_frame);

    spi_hold_frontend dut (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck),
        .si_pin(si), .hold_n_pin(hold_n), .strap_addr(STRAP),
        .tx_byte(tx_byte), .so_data(so_data), .so_en(so_en),
        .rx_byte(rx_byte), .rx_strobe(rx_strobe), .rw_bit(rw_bit),
        .frame_valid(frame_valid), .frame_end(frame_end),
        .frame_bytes(frame_bytes)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor strobes and frame-end pulses away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_strobe && prev_strobe) check(0, "R2 strobe width", 2, 1);
            if (frame_end && prev_end) check(0, "R9 end width", 2, 1);
            if (rx_strobe) begin
                if (strobe_frame < 16) cap[strobe_frame] = rx_byte;
                strobe_frame++;
                strobe_total++;
            end
            if (frame_end) begin
                n_end++;
                last_fb = frame_bytes;
            end
        end
        prev_strobe = rx_strobe;
        prev_end    = frame_end;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One byte MSB first; optional pause before bit position hold_at
    task automatic send_byte(input logic [7:0] b, input int hold_at,
                             output logic [7:0] so_got, output bit en_any,
                             output bit hold_quiet);
        so_got = 0; en_any = 0; hold_quiet = 1;
        for (int i = 7; i >= 0; i--) begin
            if (i == hold_at) begin
                hold_n = 1'b0;
                wait_clk(HALF);
                for (int p = 0; p < 2; p++) begin
                    sck = 1'b1; wait_clk(HALF);
                    if (so_en) hold_quiet = 0;
                    sck = 1'b0; wait_clk(HALF);
                    if (so_en) hold_quiet = 0;
                end
                hold_n = 1'b1;
            end
            si = b[i];
            wait_clk(HALF);
            so_got[i] = so_data;
            if (so_en) en_any = 1;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    // Full frame: id byte, ndata bytes, optional trailing partial bits
    task automatic run_frame(input logic [7:0] id, input int ndata, input int seed,
                             input int hold_byte, input int hold_at,
                             input int abort_bits, input string name);
        bit match, rd, en_any, quiet, en_frame;
        logic [7:0] got;
        int ends_before, fb_exp;
        match = (id[7:3] == 5'b01010) && (id[2:1] == STRAP);
        rd = id[0];
        en_frame = 0;
        ends_before = n_end;
        strobe_frame = 0;
        cs_n = 1'b0;
        wait_clk(HALF);
        send_byte(id, -1, got, en_any, quiet);
        for (int k = 1; k <= ndata; k++) begin
            send_byte(dat_pat(seed, k), (k == hold_byte) ? hold_at : -1,
                      got, en_any, quiet);
            if (en_any) en_frame = 1;
            if (k == hold_byte)
                check(quiet, {"R7 output released while paused ", name}, 0, 0);
            if (match && rd && k <= 16)
                check(got == tx_pat(k - 1), {"R8 read byte ", name}, got, tx_pat(k - 1));
            if (match && rd)
                check(en_any, {"R8 output driven ", name}, en_any, 1);
        end
        for (int a = 0; a < abort_bits; a++) begin
            si = 1'b1; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
        end
        wait_clk(HALF);
        check(frame_valid == match, {"R3 frame_valid ", name}, frame_valid, match);
        if (match) check(rw_bit == rd, {"R3 rw_bit ", name}, rw_bit, rd);
        if (!(match && rd))
            check(!en_frame, {"R4/R8 output never driven ", name}, en_frame, 0);
        check(strobe_frame == (match ? ndata : 0), {"R2/R4 strobe count ", name},
              strobe_frame, match ? ndata : 0);
        if (match) begin
            for (int k = 1; k <= ndata && k <= 16; k++)
                check(cap[k-1] == dat_pat(seed, k), {"R2 rx_byte ", name},
                      cap[k-1], dat_pat(seed, k));
        end
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        fb_exp = match ? ((ndata + 1 > 255) ? 255 : ndata + 1) : 1;
        check(n_end == ends_before + 1, {"R9 one frame end ", name}, n_end - ends_before, 1);
        check(last_fb == fb_exp, {"R9 frame_bytes ", name}, last_fb, fb_exp);
        check(!so_en, {"R5 released after deselect ", name}, so_en, 0);
    endtask

    function automatic logic [7:0] good_id(input bit rd);
        return {4'b0101, 1'b0, STRAP, rd};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic [7:0] got;
        bit en_any, quiet;
        int ends0, strobes0;
        // R1: reset state, with chip select held low through reset
        wait_clk(5);
        check(!so_en && !rx_strobe && !frame_valid && !frame_end, "R1 reset outputs",
              {so_en, rx_strobe, frame_valid, frame_end}, 0);
        rst_n = 1'b1;
        wait_clk(HALF);
        // R6: frame already running at reset release is not accepted
        ends0 = n_end; strobes0 = strobe_total;
        send_byte(good_id(1'b0), -1, got, en_any, quiet);
        send_byte(8'h99, -1, got, en_any, quiet);
        check(!frame_valid, "R6 no match before CS fall", frame_valid, 0);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
        check(n_end == ends0, "R6 no frame end before CS fall", n_end - ends0, 0);
        check(strobe_total == strobes0, "R6 no strobe before CS fall",
              strobe_total - strobes0, 0);

        run_frame(good_id(1'b1), 3, 1, -1, -1, 0, "read3");
        run_frame(good_id(1'b0), 3, 2, -1, -1, 0, "write3");
        run_frame({4'b0111, 1'b0, STRAP, 1'b1}, 2, 3, -1, -1, 0, "bad type");
        run_frame({4'b0101, 1'b1, STRAP, 1'b1}, 2, 4, -1, -1, 0, "bad zero bit");
        run_frame({4'b0101, 1'b0, ~STRAP, 1'b1}, 2, 5, -1, -1, 0, "bad addr");
        // R7: pause at the same instant as the reload falling edge
        run_frame(good_id(1'b1), 3, 6, 2, 7, 0, "pause at byte start");
        run_frame(good_id(1'b1), 3, 7, 1, 3, 0, "pause mid byte");
        // R5: partial byte is discarded, next frame starts clean
        run_frame(good_id(1'b0), 1, 8, -1, -1, 5, "abort partial");
        run_frame(good_id(1'b1), 2, 9, -1, -1, 0, "after abort");
        // R9: byte count saturation
        run_frame(good_id(1'b0), 260, 10, -1, -1, 0, "saturate");

        // Random frames with a fixed seed
        void'($urandom(32'h5eed_1234));
        for (int f = 0; f < 30; f++) begin
            logic [7:0] id;
            int nd, hb, ha, ab;
            id = good_id(1'($urandom_range(0, 1)));
            case ($urandom_range(0, 7))
                0: id[7:4] = 4'($urandom_range(0, 15)) ^ 4'b1000;
                1: id[2:1] = ~STRAP;
                default: ;
            endcase
            nd = $urandom_range(0, 4);
            hb = ($urandom_range(0, 2) == 0 && nd > 0) ? $urandom_range(1, nd) : -1;
            ha = $urandom_range(0, 7);
            ab = ($urandom_range(0, 4) == 0) ? $urandom_range(1, 7) : 0;
            run_frame(id, nd, 100 + f, hb, ha, ab, "random");
        end
        finish_run();
    end

endmodule